// File: doc/BRIEF.md
# Invalid Block Map Builder

This block builds a one-bit-per-block map of unusable erase blocks for a NAND-style storage array and keeps that map current while the system runs. A start pulse clears the map. The block then walks every erase block in ascending order. For each block it reads the first byte of the block's first page and of its second page through a simple request/acknowledge read port. A fresh, unused location reads as all ones (FFh). Any other value is a factory mark, and the block is recorded as invalid.

When the walk finishes, a one-cycle done pulse is raised. From then on, the owner of the array can report program or erase results. A result whose status byte has bit 0 set adds that block to the map, so the block is not used again. Other logic can read the map one block at a time through a registered lookup port. A running count of invalid blocks is exposed at all times.

Two limits are enforced. The first block of the array is guaranteed good, so it is never entered in the map, and any mark against it raises a sticky error flag instead. More than the allowed number of invalid blocks raises a sticky reject alarm.

Top module: `blkmap_scan`

## Requirements
- R1: After reset, and in the cycle after a `start` pulse, the map is all zero, `badCount` is 0, and `limitAlarm`, `blk0Err` and `scanDone` are low.
- R2: A scan issues exactly two reads per block, for blocks 0 up to NUM_BLOCKS-1 in ascending order. Block b reads row b*PAGES_PER_BLK first and then row b*PAGES_PER_BLK+1. `rdReq` and `rdRow` stay stable until `rdAck` is seen. No further read is issued after the last block.
- R3: A block other than block 0 is marked invalid when either of its two marker bytes differs from FFh, including single-bit differences. A block is counted once, even if both bytes are marked.
- R4: Block 0 never reads as invalid through the lookup port. Any mark or fail report against block 0 sets `blk0Err` and leaves `badCount` unchanged.
- R5: `limitAlarm` is high exactly when `badCount` exceeds MAX_BAD (10 by default). At 10 invalid blocks it stays low.
- R6: `scanDone` is high for exactly one cycle once the second read of the last block is acknowledged, and the count already includes that block.
- R7: After done, a report with `failValid` high and `failStatus` bit 0 equal to 1 marks `failBlk` invalid and raises `badCount` by one. A report with bit 0 equal to 0, or against an already marked block, leaves `badCount` and the map unchanged.
- R8: Fail reports given between `start` and `scanDone` are ignored.
- R9: `lookupBad` shows the map bit of `lookupBlk` one clock after `lookupBlk` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: clear the map and begin a scan |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdRow | output | ROW_W (13) | Row address of the requested marker byte (column 0) |
| rdAck | input | 1 | Read acknowledge; `rdByte` is valid with it |
| rdByte | input | DATA_W (8) | Marker byte returned by the read |
| failValid | input | 1 | A program/erase result is presented |
| failBlk | input | BLK_W (9) | Block the result refers to |
| failStatus | input | DATA_W (8) | Status byte of the result; bit 0 = 1 means failed |
| lookupBlk | input | BLK_W (9) | Block to look up |
| lookupBad | output | 1 | Map bit of the looked-up block, one cycle later |
| badCount | output | CNT_W (10) | Number of blocks in the map |
| limitAlarm | output | 1 | Count exceeds MAX_BAD |
| blk0Err | output | 1 | A mark or failure was seen on block 0 |
| scanDone | output | 1 | One-cycle pulse when the scan ends |

## Verification
Scans are run over four kinds of array content:
- An all-erased array. This shows the walk order, the read count and the done pulse, with no marks in play.
- Marks in page 0 only, in page 1 only, in both pages of one block, and single-bit deviations such as FEh and 7Fh. These separate the two-page test from single-count logic and from an exact-zero compare.
- A mark on block 0. This checks that the exemption holds and that the error flag is raised.
- Exactly ten marks followed by one fail report. This locates the alarm threshold at the boundary.

Fail reports with bit 0 clear, against blocks already in the map, and during an active scan confirm that only valid post-scan failures change the map.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PG0,
    ST_PG1
  } scan_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTable;  // wipe map, count, flags; rewind block counter
    logic scanMark;  // current marker byte is not erased
    logic blkAdv;    // step to next block
    logic finish;    // last read of the scan completed
    logic pageSel;   // 0: first page, 1: second page
  } scan_strobe_t;

endpackage

// File: rtl/blkmap_ctrl.sv
module blkmap_ctrl
  import blkmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdByte,
  input  logic              lastBlk,
  output logic              rdReq,
  output scan_strobe_t      strb
);

  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  scan_state_e state, stateNext;
  logic byteMarked;

  assign byteMarked = (rdByte != ERASED);

  always_comb begin
    strb      = '0;
    stateNext = state;
    rdReq     = (state != ST_IDLE);
    strb.pageSel = (state == ST_PG1);
    if (start) begin
      strb.clrTable = 1'b1;
      stateNext     = ST_PG0;
    end else begin
      case (state)
        ST_PG0: begin
          if (rdAck) begin
            strb.scanMark = byteMarked;
            stateNext     = ST_PG1;
          end
        end
        ST_PG1: begin
          if (rdAck) begin
            strb.scanMark = byteMarked;
            if (lastBlk) begin
              strb.finish = 1'b1;
              stateNext   = ST_IDLE;
            end else begin
              strb.blkAdv = 1'b1;
              stateNext   = ST_PG0;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/blkmap_dpath.sv
module blkmap_dpath
  import blkmap_pkg::*;
#(
  parameter int NUM_BLOCKS    = 512,
  parameter int PAGES_PER_BLK = 16,
  parameter int MAX_BAD       = 10,
  parameter int DATA_W        = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLK),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_strobe_t      strb,
  input  logic              failValid,
  input  logic [BLK_W-1:0]  failBlk,
  input  logic [DATA_W-1:0] failStatus,
  input  logic [BLK_W-1:0]  lookupBlk,
  output logic [ROW_W-1:0]  rdRow,
  output logic              lastBlk,
  output logic              lookupBad,
  output logic [CNT_W-1:0]  badCount,
  output logic              limitAlarm,
  output logic              blk0Err,
  output logic              scanDone
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(MAX_BAD);

  logic [NUM_BLOCKS-1:0] badMap;
  logic [BLK_W-1:0]      blkCnt;
  logic                  tableReady;

  logic             failTake, markEn, markZero, markNew;
  logic [BLK_W-1:0] markIdx;
  logic [CNT_W-1:0] countNext;

  assign rdRow   = ROW_W'(blkCnt) * ROW_W'(PAGES_PER_BLK) + ROW_W'(strb.pageSel);
  assign lastBlk = (blkCnt == LAST_BLK);

  assign failTake  = tableReady && failValid && failStatus[0] && !strb.clrTable;
  assign markEn    = strb.scanMark || failTake;
  assign markIdx   = strb.scanMark ? blkCnt : failBlk;
  assign markZero  = (markIdx == '0);
  assign markNew   = markEn && !markZero && !badMap[markIdx];
  assign countNext = badCount + CNT_W'(markNew);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badMap     <= '0;
      blkCnt     <= '0;
      tableReady <= 1'b0;
      badCount   <= '0;
      limitAlarm <= 1'b0;
      blk0Err    <= 1'b0;
      scanDone   <= 1'b0;
      lookupBad  <= 1'b0;
    end else begin
      lookupBad <= badMap[lookupBlk];
      if (strb.clrTable) begin
        badMap     <= '0;
        blkCnt     <= '0;
        tableReady <= 1'b0;
        badCount   <= '0;
        limitAlarm <= 1'b0;
        blk0Err    <= 1'b0;
        scanDone   <= 1'b0;
      end else begin
        scanDone <= strb.finish;
        if (strb.finish) tableReady <= 1'b1;
        if (strb.blkAdv) blkCnt <= blkCnt + 1'b1;
        if (markNew) badMap[markIdx] <= 1'b1;
        if (markEn && markZero) blk0Err <= 1'b1;
        badCount   <= countNext;
        limitAlarm <= (countNext > LIMIT);
      end
    end
  end

endmodule

// File: rtl/blkmap_scan.sv
module blkmap_scan
  import blkmap_pkg::*;
#(
  parameter int NUM_BLOCKS    = 512,
  parameter int PAGES_PER_BLK = 16,
  parameter int MAX_BAD       = 10,
  parameter int DATA_W        = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLK),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              rdReq,
  output logic [ROW_W-1:0]  rdRow,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdByte,
  input  logic              failValid,
  input  logic [BLK_W-1:0]  failBlk,
  input  logic [DATA_W-1:0] failStatus,
  input  logic [BLK_W-1:0]  lookupBlk,
  output logic              lookupBad,
  output logic [CNT_W-1:0]  badCount,
  output logic              limitAlarm,
  output logic              blk0Err,
  output logic              scanDone
);

  scan_strobe_t strb;
  logic         lastBlk;

  blkmap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rdAck   (rdAck),
    .rdByte  (rdByte),
    .lastBlk (lastBlk),
    .rdReq   (rdReq),
    .strb    (strb)
  );

  blkmap_dpath #(
    .NUM_BLOCKS    (NUM_BLOCKS),
    .PAGES_PER_BLK (PAGES_PER_BLK),
    .MAX_BAD       (MAX_BAD),
    .DATA_W        (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .failValid  (failValid),
    .failBlk    (failBlk),
    .failStatus (failStatus),
    .lookupBlk  (lookupBlk),
    .rdRow      (rdRow),
    .lastBlk    (lastBlk),
    .lookupBad  (lookupBad),
    .badCount   (badCount),
    .limitAlarm (limitAlarm),
    .blk0Err    (blk0Err),
    .scanDone   (scanDone)
  );

endmodule

// File: rtl/blkmap_scan_chk.sv
module blkmap_scan_chk #(
  parameter int NUM_BLOCKS    = 512,
  parameter int PAGES_PER_BLK = 16,
  parameter int MAX_BAD       = 10,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLK),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             rdReq,
  input logic [ROW_W-1:0] rdRow,
  input logic             rdAck,
  input logic [BLK_W-1:0] lookupBlk,
  input logic             lookupBad,
  input logic [CNT_W-1:0] badCount,
  input logic             limitAlarm,
  input logic             scanDone
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && !start) |=> (rdReq && $stable(rdRow)));

  p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !start) |-> !rdReq);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (badCount == $past(badCount) || badCount == $past(badCount) + 1'b1));

  p_blk0_good_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lookupBlk == '0) |=> !lookupBad);

  p_alarm_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    limitAlarm == (badCount > CNT_W'(MAX_BAD)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (badCount == '0 && !limitAlarm && !scanDone));

endmodule

bind blkmap_scan blkmap_scan_chk #(
  .NUM_BLOCKS    (NUM_BLOCKS),
  .PAGES_PER_BLK (PAGES_PER_BLK),
  .MAX_BAD       (MAX_BAD)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .rdReq      (rdReq),
  .rdRow      (rdRow),
  .rdAck      (rdAck),
  .lookupBlk  (lookupBlk),
  .lookupBad  (lookupBad),
  .badCount   (badCount),
  .limitAlarm (limitAlarm),
  .scanDone   (scanDone)
);

// File: tb/blkmap_scan_test.sv
module blkmap_scan_test;

  localparam int NB = 512;
  localparam int PG = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       rdReq;
  logic [12:0] rdRow;
  logic       rdAck = 1'b0;
  logic [7:0] rdByte = 8'hFF;
  logic       failValid = 1'b0;
  logic [8:0] failBlk = '0;
  logic [7:0] failStatus = '0;
  logic [8:0] lookupBlk = '0;
  logic       lookupBad;
  logic [9:0] badCount;
  logic       limitAlarm, blk0Err, scanDone;

  int total = 0;
  int bad = 0;
  logic [7:0] pg0 [NB];
  logic [7:0] pg1 [NB];
  int expBlk = 0;
  int expPg = 0;
  int readCnt = 0;
  int orderErr = 0;

  blkmap_scan uut (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory responder: acknowledge one negedge after a pending request
  initial begin
    forever begin
      @(negedge clk);
      if (rdAck) rdAck = 1'b0;
      else if (rdReq) begin
        if (int'(rdRow) != expBlk * PG + expPg) orderErr++;
        rdByte = (rdRow[0] == 1'b0) ? pg0[rdRow / PG] : pg1[rdRow / PG];
        rdAck = 1'b1;
        readCnt++;
        if (expPg == 0) expPg = 1;
        else begin expPg = 0; expBlk++; end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic eraseMem();
    for (int i = 0; i < NB; i++) begin pg0[i] = 8'hFF; pg1[i] = 8'hFF; end
  endtask

  task automatic runScan(input int expCount);
    int waitN = 0;
    @(negedge clk);
    expBlk = 0; expPg = 0; readCnt = 0; orderErr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(badCount == 0 && !blk0Err && !limitAlarm, "R1 clear on start", badCount, 0);
    while (!scanDone && waitN < 5000) begin @(negedge clk); waitN++; end
    check(scanDone, "R6 done seen", scanDone, 1);
    check(badCount == expCount, "R6/R3 count at done", badCount, expCount);
    @(negedge clk);
    check(!scanDone, "R6 single-cycle done", scanDone, 0);
    repeat (4) @(negedge clk);
    check(!rdReq && readCnt == 2 * NB, "R2 read total, stop after last", readCnt, 2 * NB);
    check(orderErr == 0, "R2 row order", orderErr, 0);
  endtask

  task automatic look(input int blk, input bit exp, input string req);
    @(negedge clk);
    lookupBlk = 9'(blk);
    @(negedge clk);
    check(lookupBad == exp, req, lookupBad, exp);
  endtask

  task automatic report(input int blk, input logic [7:0] st);
    @(negedge clk);
    failBlk = 9'(blk); failStatus = st; failValid = 1'b1;
    @(negedge clk);
    failValid = 1'b0;
  endtask

  task automatic t_reset();
    check(!rdReq && !scanDone && badCount == 0 && !limitAlarm && !blk0Err && !lookupBad,
          "R1 reset state", badCount, 0);
  endtask

  task automatic t_clean();
    eraseMem();
    runScan(0);
    look(1, 1'b0, "R9 clean lookup");
    check(!limitAlarm && !blk0Err, "R5 no alarm on clean", limitAlarm, 0);
  endtask

  task automatic t_marks();
    eraseMem();
    pg0[5] = 8'h00; pg1[77] = 8'h00; pg0[200] = 8'hFE; pg1[511] = 8'h7F;
    pg0[300] = 8'h00; pg1[300] = 8'h00;
    runScan(5);
    look(5, 1'b1, "R3 page0 mark");
    look(77, 1'b1, "R3 page1 mark");
    look(200, 1'b1, "R3 single-bit mark");
    look(511, 1'b1, "R3 last block mark");
    look(300, 1'b1, "R3 both pages");
    look(6, 1'b0, "R9 neighbour clear");
  endtask

  task automatic t_blk0();
    eraseMem();
    pg1[0] = 8'h00;
    runScan(0);
    check(blk0Err, "R4 block 0 flag", blk0Err, 1);
    look(0, 1'b0, "R4 block 0 not mapped");
  endtask

  task automatic t_limit();
    eraseMem();
    for (int i = 1; i <= 10; i++) pg0[i * 3] = 8'h00;
    runScan(10);
    check(!limitAlarm, "R5 ten is allowed", limitAlarm, 0);
    report(40, 8'h01);
    check(badCount == 11, "R7 fail report counted", badCount, 11);
    check(limitAlarm, "R5 eleven alarms", limitAlarm, 1);
  endtask

  task automatic t_reports();
    eraseMem();
    pg0[8] = 8'h00;
    runScan(1);
    report(9, 8'hC1);
    check(badCount == 2, "R7 bit0 set marks", badCount, 2);
    look(9, 1'b1, "R7 reported block mapped");
    report(10, 8'hC0);
    check(badCount == 2, "R7 bit0 clear ignored", badCount, 2);
    look(10, 1'b0, "R7 bit0 clear not mapped");
    report(8, 8'h01);
    check(badCount == 2, "R7 already marked once", badCount, 2);
    report(0, 8'h01);
    check(badCount == 2 && blk0Err, "R4 fail on block 0", badCount, 2);
    look(0, 1'b0, "R4 block 0 still good");
  endtask

  task automatic t_during_scan();
    int waitN = 0;
    eraseMem();
    @(negedge clk);
    expBlk = 0; expPg = 0; readCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(badCount == 0 && !blk0Err, "R1 start clears prior state", badCount, 0);
    repeat (100) @(negedge clk);
    report(400, 8'h01);
    while (!scanDone && waitN < 5000) begin @(negedge clk); waitN++; end
    check(badCount == 0, "R8 report during scan ignored", badCount, 0);
    look(400, 1'b0, "R8 block not mapped");
  endtask

  initial begin
    eraseMem();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_clean();
    t_marks();
    t_blk0();
    t_limit();
    t_reports();
    t_during_scan();
    summary();
  end

endmodule